// File: doc/BRIEF.md
# Two-Wire Register Slave with Auto-Increment

This block is a slave on a two-wire serial bus. It gives a host read and write access to a bank of 8-bit control registers and one read-only status byte. SCL and SDA arrive as raw levels and are oversampled by the system clock. Each line passes through a two-flop synchronizer and a glitch filter before the bus engine sees it. The engine recognises START, repeated START and STOP conditions. It matches a 7-bit device address whose lowest bit comes from a select pin, and it acknowledges by pulling SDA low.

After a write-mode address, the first byte sets a register pointer. Every later byte is stored at the pointer, and the pointer then advances by one. A read first sets the pointer in write mode. A repeated START follows, with or without a STOP before it, and then the read-mode address. Bytes are then shifted out MSB first, and the pointer advances after each byte. The stored register contents are exposed as a flat vector, together with a one-cycle write strobe per register, so the rest of the chip can use them.

Top module: `twi_regbank`

## Requirements
- R1: With `addr_sel` = s, the device address is 7'b100110s. A first byte after START whose upper seven bits equal this address gets an acknowledge: SDA is held low through the 9th SCL clock.
- R2: When the address does not match, SDA is not driven in the acknowledge slot. SDA stays released for the rest of the transfer, and no register or strobe changes until the next START.
- R3: A START (SDA falling while SCL is high) restarts address reception at any point, including in the middle of a transfer. A STOP (SDA rising while SCL is high) ends the transfer. A byte cut short by either condition is not stored.
- R4: In a write, the byte after the address loads the pointer. Each following byte is acknowledged and stored at the pointer, and the pointer then increments by one. Each stored byte pulses that register's `cfg_wr_stb` bit for exactly one cycle.
- R5: After a read-mode address, the byte at the pointer is driven MSB first, each bit changing only while SCL is low. The pointer increments after each byte. A STOP between the pointer phase and the read START does not change the pointer.
- R6: In a read, the slave releases SDA in the acknowledge slot. If the master answers with a NACK (SDA high), the slave drives nothing more until the next START or STOP, so further clocks read 0xFF.
- R7: Sub-address 0x14 reads the live `status_in` value, and its `cfg_regs` slot shows `status_in`. Writes to 0x14 are acknowledged but store nothing and raise no strobe.
- R8: Reserved bits are dropped on write and read back as 0. These are bits 2:0 of 0x03, bits 2:0 of 0x04, and bit 0 of 0x0F. All other bits of 0x03..0x15 are writable.
- R9: Sub-addresses outside 0x03..0x15 are acknowledged on write but not stored, and they read as 0x00. Register 0x03+i occupies `cfg_regs[8*i +: 8]`.
- R10: A pulse on SCL or SDA that lasts fewer than `FILT_LEN` system clocks (default 4) is ignored and causes no bus event.
- R11: The slave changes `sda_drive_low` only while SCL is low.
- R12: After reset, `sda_drive_low` is 0, every stored register is 0, and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level (wired-AND bus value) |
| addr_sel | input | 1 | Lowest device-address bit, static during operation |
| status_in | input | 8 | Read-only status byte returned at 0x14 |
| sda_drive_low | output | 1 | 1 pulls SDA low (acknowledge or data 0) |
| cfg_regs | output | 8*NUM_REGS | Register contents, register 0x03+i in byte i |
| cfg_wr_stb | output | NUM_REGS | One-cycle pulse per stored write, bit i for 0x03+i |

## Verification
A line change reaches the engine 2+`FILT_LEN` clocks after it appears on the pins, and the acknowledge or data level follows one clock later. The bench therefore changes SDA only after waiting a quarter SCL period (10 clocks) following an SCL fall, and it samples SDA at the middle of SCL high, well past that latency. A stored byte lands in `cfg_regs` one clock after the acknowledge edge. Register contents are compared only after STOP plus idle time, and every read byte is compared with a bench shadow built from the mask and range rules. A clock-by-clock monitor counts any change of `sda_drive_low` while SCL is high, and any drive inside windows where the slave must be silent.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_SUB,
    PH_WR,
    PH_RD,
    PH_WAIT
  } phase_t;

  localparam logic [5:0] DEV_ADDR_HI = 6'b100110;

  // Writable bit mask per sub-address; reserved bits are cleared.
  function automatic logic [7:0] keep_mask(input logic [7:0] sub);
    case (sub)
      8'h03, 8'h04: keep_mask = 8'hF8;
      8'h0F:        keep_mask = 8'hFE;
      default:      keep_mask = 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/twi_glitch_filter.sv
module twi_glitch_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;

  logic          s1_q, s2_q;
  logic          out_q, out_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    out_n = out_q;
    cnt_n = '0;
    if (s2_q != out_q) begin
      if (cnt_q == CW'(FILT_LEN - 1)) out_n = s2_q;
      else                            cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      out_q <= out_n;
      cnt_q <= cnt_n;
    end
  end

  assign dout = out_q;

  // R10: the filtered level only ever moves to the synchronized input level
  assert_filter_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> (out_q == $past(s2_q)));

  // R10: agreeing input never moves the output
  assert_filter_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_q == out_q) |=> $stable(out_q));

endmodule

// File: rtl/twi_bus_engine.sv
module twi_bus_engine
  import twi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl,
  input  logic       sda,
  input  logic       addr_sel,
  input  logic [7:0] rd_data,
  output logic [7:0] ptr,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       sda_low
);
  phase_t     phase_q, phase_n;
  logic [3:0] cnt_q, cnt_n;
  logic [7:0] sh_q, sh_n;
  logic [7:0] tx_q, tx_n;
  logic [7:0] ptr_q, ptr_n;
  logic       rw_q, rw_n;
  logic       mack_q, mack_n;
  logic       drv_q, drv_n;
  logic       scl_q, sda_q;

  logic scl_rise, scl_fall, start_ev, stop_ev, active;

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign start_ev = scl & scl_q & sda_q & ~sda;
  assign stop_ev  = scl & scl_q & ~sda_q & sda;
  assign active   = (phase_q != PH_IDLE) && (phase_q != PH_WAIT);

  always_comb begin
    phase_n = phase_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    tx_n    = tx_q;
    ptr_n   = ptr_q;
    rw_n    = rw_q;
    mack_n  = mack_q;
    drv_n   = drv_q;
    wr_en   = 1'b0;
    wr_addr = ptr_q;
    wr_data = sh_q;
    if (start_ev) begin
      phase_n = PH_DEV;
      cnt_n   = '0;
      drv_n   = 1'b0;
    end else if (stop_ev) begin
      phase_n = PH_IDLE;
      cnt_n   = '0;
      drv_n   = 1'b0;
    end else if (active) begin
      if (scl_rise) begin
        if (cnt_q < 4'd8) begin
          sh_n  = {sh_q[6:0], sda};
          cnt_n = cnt_q + 4'd1;
        end else begin
          mack_n = ~sda;
          cnt_n  = 4'd9;
        end
      end else if (scl_fall) begin
        if (cnt_q == 4'd8) begin
          case (phase_q)
            PH_DEV: begin
              if (sh_q[7:1] == {DEV_ADDR_HI, addr_sel}) begin
                drv_n = 1'b1;
                rw_n  = sh_q[0];
              end else begin
                phase_n = PH_WAIT;
                drv_n   = 1'b0;
              end
            end
            PH_SUB: begin
              ptr_n = sh_q;
              drv_n = 1'b1;
            end
            PH_WR: begin
              wr_en = 1'b1;
              ptr_n = ptr_q + 8'd1;
              drv_n = 1'b1;
            end
            default: drv_n = 1'b0;
          endcase
        end else if (cnt_q == 4'd9) begin
          cnt_n = '0;
          drv_n = 1'b0;
          case (phase_q)
            PH_DEV: begin
              if (rw_q) begin
                phase_n = PH_RD;
                tx_n    = rd_data;
                ptr_n   = ptr_q + 8'd1;
                drv_n   = ~rd_data[7];
              end else begin
                phase_n = PH_SUB;
              end
            end
            PH_SUB: phase_n = PH_WR;
            PH_RD: begin
              if (mack_q) begin
                tx_n  = rd_data;
                ptr_n = ptr_q + 8'd1;
                drv_n = ~rd_data[7];
              end else begin
                phase_n = PH_WAIT;
              end
            end
            default: phase_n = phase_q;
          endcase
        end else if ((phase_q == PH_RD) && (cnt_q != 4'd0)) begin
          tx_n  = {tx_q[6:0], 1'b0};
          drv_n = ~tx_q[6];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      drv_q   <= 1'b0;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
    end else begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      tx_q    <= tx_n;
      ptr_q   <= ptr_n;
      rw_q    <= rw_n;
      mack_q  <= mack_n;
      drv_q   <= drv_n;
      scl_q   <= scl;
      sda_q   <= sda;
    end
  end

  assign ptr     = ptr_q;
  assign sda_low = drv_q;

  // R11: the SDA drive moves only at an edge where SCL is low
  assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drv_q) |-> !$past(scl));

  // R2: a rejected or finished transfer never drives the bus
  assert_wait_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT) |-> !drv_q);

  // R4: every stored byte is acknowledged in the next cycle
  assert_write_acked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> drv_q);

endmodule

// File: rtl/twi_reg_file.sv
module twi_reg_file
  import twi_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR = 8'h03,
  parameter int         NUM_REGS  = 19,
  parameter logic [7:0] RO_ADDR   = 8'h14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [7:0]            rd_addr,
  input  logic [7:0]            status_in,
  output logic [7:0]            rd_data,
  output logic [8*NUM_REGS-1:0] cfg_flat,
  output logic [NUM_REGS-1:0]   wr_stb
);
  logic [7:0] slot [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] SUB  = 8'(int'(BASE_ADDR) + i);
    localparam logic [7:0] MASK = keep_mask(SUB);
    if (SUB == RO_ADDR) begin : g_ro
      assign slot[i]   = status_in;
      assign wr_stb[i] = 1'b0;
    end else begin : g_rw
      logic [7:0] val_q, val_n;
      logic       hit, stb_q;
      assign hit = wr_en && (wr_addr == SUB);
      always_comb begin
        val_n = val_q;
        if (hit) val_n = wr_data & MASK;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          val_q <= '0;
          stb_q <= 1'b0;
        end else begin
          val_q <= val_n;
          stb_q <= hit;
        end
      end
      assign slot[i]   = val_q;
      assign wr_stb[i] = stb_q;

      // R8: reserved bits of a stored register stay clear
      assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (val_q & ~MASK) == 8'h00);
    end
    assign cfg_flat[8*i +: 8] = slot[i];
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr == 8'(int'(BASE_ADDR) + i)) rd_data = slot[i];
    end
  end

  // R4: at most one register is strobed per cycle
  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));

endmodule

// File: rtl/twi_regbank.sv
module twi_regbank #(
  parameter int         FILT_LEN  = 4,
  parameter logic [7:0] BASE_ADDR = 8'h03,
  parameter int         NUM_REGS  = 19,
  parameter logic [7:0] RO_ADDR   = 8'h14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_in,
  input  logic                  sda_in,
  input  logic                  addr_sel,
  input  logic [7:0]            status_in,
  output logic                  sda_drive_low,
  output logic [8*NUM_REGS-1:0] cfg_regs,
  output logic [NUM_REGS-1:0]   cfg_wr_stb
);
  logic [1:0] rst_sq;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_core_n = rst_sq[1];

  logic [1:0] line_raw, line_flt;
  assign line_raw = {sda_in, scl_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    twi_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst_n(rst_core_n),
      .din  (line_raw[g]),
      .dout (line_flt[g])
    );
  end

  logic [7:0] ptr, rd_data, wr_addr, wr_data;
  logic       wr_en;

  twi_bus_engine u_engine (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .scl     (line_flt[0]),
    .sda     (line_flt[1]),
    .addr_sel(addr_sel),
    .rd_data (rd_data),
    .ptr     (ptr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .sda_low (sda_drive_low)
  );

  twi_reg_file #(
    .BASE_ADDR(BASE_ADDR),
    .NUM_REGS (NUM_REGS),
    .RO_ADDR  (RO_ADDR)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (ptr),
    .status_in(status_in),
    .rd_data  (rd_data),
    .cfg_flat (cfg_regs),
    .wr_stb   (cfg_wr_stb)
  );

endmodule

// File: tb/tb_twi_regbank.sv
module tb_twi_regbank;
  localparam int NREG = 19;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic addr_sel = 1'b0;
  logic [7:0] status_in = 8'h5A;
  logic sda_drive_low;
  logic [8*NREG-1:0] cfg_regs;
  logic [NREG-1:0] cfg_wr_stb;
  logic sda_bus;

  assign sda_bus = sda_m & ~sda_drive_low;

  twi_regbank dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .addr_sel(addr_sel), .status_in(status_in),
    .sda_drive_low(sda_drive_low), .cfg_regs(cfg_regs), .cfg_wr_stb(cfg_wr_stb)
  );

  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;
  int high_changes = 0;
  int silent_drives = 0;
  bit silent = 1'b0;
  int stb_cnt [NREG];
  logic prev_drv = 1'b0;
  logic [7:0] shadow [256];

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst_n) begin
      if (scl_m && (sda_drive_low != prev_drv)) high_changes++;
      if (silent && sda_drive_low) silent_drives++;
      for (int i = 0; i < NREG; i++) if (cfg_wr_stb[i]) stb_cnt[i]++;
    end
    prev_drv = sda_drive_low;
    if (cycles == 150000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=finish", cycles);
      summary();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bmask(input logic [7:0] a);
    if (a == 8'h03 || a == 8'h04) return 8'hF8;
    if (a == 8'h0F) return 8'hFE;
    return 8'hFF;
  endfunction

  function automatic bit in_bank(input logic [7:0] a);
    return (a >= 8'h03) && (a <= 8'h15) && (a != 8'h14);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a == 8'h14) return status_in;
    if (in_bank(a)) return shadow[a];
    return 8'h00;
  endfunction

  function automatic logic [7:0] slot(input int i);
    return cfg_regs[8*i +: 8];
  endfunction

  task automatic qw; repeat (Q) @(negedge clk); endtask

  task automatic m_start;
    scl_m = 1'b0; qw(); sda_m = 1'b1; qw();
    scl_m = 1'b1; qw(); sda_m = 1'b0; qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic m_stop;
    scl_m = 1'b0; sda_m = 1'b0; qw();
    scl_m = 1'b1; qw(); sda_m = 1'b1; qw(); qw();
  endtask

  task automatic wbit(input logic b, input bit g_sda, input bit g_scl);
    sda_m = b;
    if (g_scl) begin
      repeat (3) @(negedge clk);
      scl_m = 1'b1; repeat (2) @(negedge clk); scl_m = 1'b0;
      repeat (Q-5) @(negedge clk);
    end else qw();
    scl_m = 1'b1;
    if (g_sda) begin
      repeat (5) @(negedge clk);
      sda_m = 1'b0; repeat (2) @(negedge clk); sda_m = 1'b1;
      repeat (2*Q-7) @(negedge clk);
    end else begin
      qw(); qw();
    end
    scl_m = 1'b0; qw();
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; qw();
    scl_m = 1'b1; qw(); b = sda_bus; qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic send(input logic [7:0] d, output bit ack);
    logic x;
    for (int i = 7; i >= 0; i--) wbit(d[i], 1'b0, 1'b0);
    rbit(x);
    ack = ~x;
  endtask

  task automatic recv(output logic [7:0] d, input logic nack);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(nack, 1'b0, 1'b0);
  endtask

  task automatic mwrite(input logic [7:0] a, input logic [7:0] d);
    if (in_bank(a)) shadow[a] = d & bmask(a);
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    logic [7:0] d;
    int tot;
    for (int i = 0; i < 256; i++) shadow[i] = 8'h00;
    for (int i = 0; i < NREG; i++) stb_cnt[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R12: reset state
    check("R12 sda released", int'(sda_drive_low), 0);
    for (int i = 0; i < NREG; i++) check("R12 reg cleared", int'(slot(i)), (i == 17) ? 8'h5A : 0);
    check("R12 no strobe", int'(cfg_wr_stb), 0);

    // R1: address sweep with addr_sel = 0, then both sel values
    for (int a = 0; a < 128; a++) begin
      m_start(); send(8'(a << 1), ack); m_stop();
      check("R1 address ack", int'(ack), (a == 7'h4C) ? 1 : 0);
    end
    addr_sel = 1'b1;
    m_start(); send(8'h9A, ack); m_stop(); check("R1 sel1 match", int'(ack), 1);
    m_start(); send(8'h98, ack); m_stop(); check("R1 sel1 mismatch", int'(ack), 0);
    addr_sel = 1'b0;

    // R4 R7 R8 R9: burst write 0x01..0x17
    for (int i = 0; i < NREG; i++) stb_cnt[i] = 0;
    m_start(); send(8'h98, ack); send(8'h01, ack);
    check("R4 sub ack", int'(ack), 1);
    for (int a = 1; a <= 8'h17; a++) begin
      d = 8'(a * 29 + 8'hA5);
      send(d, ack); mwrite(8'(a), d);
      check("R4 R9 data ack", int'(ack), 1);
    end
    m_stop(); qw();
    for (int i = 0; i < NREG; i++) begin
      check("R4 R7 R8 reg content", int'(slot(i)), int'(exp_rd(8'(i + 3))));
      check("R4 R7 strobe count", stb_cnt[i], (i == 17) ? 0 : 1);
    end

    // R5: burst read through repeated START
    m_start(); send(8'h98, ack); send(8'h01, ack);
    m_start(); send(8'h99, ack); check("R5 read addr ack", int'(ack), 1);
    for (int a = 1; a <= 8'h17; a++) begin
      recv(b, (a == 8'h17));
      check("R5 R7 R8 R9 read byte", int'(b), int'(exp_rd(8'(a))));
    end
    m_stop();

    // R5: STOP between pointer phase and read
    m_start(); send(8'h98, ack); send(8'h10, ack); m_stop();
    m_start(); send(8'h99, ack); recv(b, 1'b0); check("R5 stop-split read", int'(b), int'(exp_rd(8'h10)));
    recv(b, 1'b1); check("R5 pointer advance", int'(b), int'(exp_rd(8'h11)));
    m_stop();

    // R6: master NACK ends the read
    m_start(); send(8'h98, ack); send(8'h05, ack);
    m_start(); send(8'h99, ack); recv(b, 1'b1);
    check("R6 byte before nack", int'(b), int'(exp_rd(8'h05)));
    silent = 1'b1; recv(b, 1'b1); silent = 1'b0;
    check("R6 released after nack", int'(b), 8'hFF);
    m_stop();

    // R2: mismatched address ignores the transfer
    tot = 0; for (int i = 0; i < NREG; i++) tot += stb_cnt[i];
    m_start(); silent = 1'b1;
    send(8'h9A, ack); check("R2 no ack", int'(ack), 0);
    send(8'h05, ack); send(8'h11, ack); send(8'h22, ack);
    silent = 1'b0; m_stop(); qw();
    check("R2 reg unchanged", int'(slot(2)), int'(shadow[8'h05]));
    for (int i = 0; i < NREG; i++) tot -= stb_cnt[i];
    check("R2 no strobes", tot, 0);

    // R3: repeated START mid-write, STOP inside a byte
    m_start(); send(8'h98, ack); send(8'h06, ack); send(8'h33, ack); mwrite(8'h06, 8'h33);
    m_start(); send(8'h98, ack); send(8'h08, ack); send(8'h44, ack); mwrite(8'h08, 8'h44);
    m_stop();
    m_start(); send(8'h98, ack); send(8'h09, ack);
    for (int i = 0; i < 4; i++) wbit(1'b0, 1'b0, 1'b0);
    m_stop(); qw();
    check("R3 first segment", int'(slot(3)), int'(shadow[8'h06]));
    check("R3 untouched between", int'(slot(4)), int'(shadow[8'h07]));
    check("R3 second segment", int'(slot(5)), int'(shadow[8'h08]));
    check("R3 cut byte dropped", int'(slot(6)), int'(shadow[8'h09]));

    // R10: short glitches on SDA (SCL high) and SCL (SCL low)
    m_start(); send(8'h98, ack); send(8'h0A, ack);
    d = 8'h96;
    for (int i = 7; i >= 0; i--) wbit(d[i], (i == 7) || (i == 2), (i == 4) || (i == 0));
    rbit(b); mwrite(8'h0A, d);
    check("R10 ack despite glitches", int'(b), 0);
    m_stop(); qw();
    check("R10 glitched byte stored", int'(slot(7)), int'(shadow[8'h0A]));

    // R7: live status value
    status_in = 8'hC3;
    m_start(); send(8'h98, ack); send(8'h14, ack);
    m_start(); send(8'h99, ack); recv(b, 1'b1); m_stop();
    check("R7 live status read", int'(b), 8'hC3);
    check("R7 status slot", int'(slot(17)), 8'hC3);

    // R11 R2: monitors
    check("R11 no drive change while SCL high", high_changes, 0);
    check("R2 R6 silent windows", silent_drives, 0);
    summary();
  end
endmodule